// File: doc/BRIEF.md
# NOR Flash Program and Erase Controller

This block sits on the host side of a parallel NOR flash device and runs byte-program and whole-chip erase operations for its client. A client hands over one request (operation, target address, data byte) on a valid/ready handshake. The controller then drives the flash bus through the series of unlock and command write cycles that the operation needs. Each cycle's chip-enable and write-enable strobes are timed in clock counts.

Once the last command write has gone out, the controller reads the target location again and again. It watches the top data bit until that bit shows the value the finished operation leaves there. The flash stops holding the address on its own once programming starts, so every poll puts the target address on the bus. A poll budget bounds the wait. When the budget runs out, the controller writes the read/reset command to get the device back to read mode and reports a timeout.

For program requests an optional pre-check is available. It reads the target first and refuses any request that would turn a 0 bit back into a 1, which only an erase can do. Each request ends with a one-cycle done pulse that carries a status code.

Top module: `nor_prog_ctrl`

## Requirements
- R1: A program request issues exactly four write cycles in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), then (target address, request data).
- R2: An erase request issues exactly six write cycles in this order: (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x80), (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0x10).
- R3: In every write cycle, the address and data are driven one clock before CE_n and WE_n fall. CE_n and WE_n stay low together for exactly STROBE_CLKS clocks. Address and data do not change while CE_n is low. The data stays driven for one clock after the strobes rise.
- R4: After the command writes, every poll read uses the target address. The operation completes with status 0 (ok) on the first poll where DQ7 equals bit 7 of the request data. For an erase, the expected DQ7 is 1.
- R5: From the last command write until done, no write cycle is issued, except the reset write described in R6.
- R6: If MAX_POLLS consecutive poll reads all fail, one write of 0xF0 to address 0 is issued and done reports status 1 (timeout).
- R7: When CHECK_ILLEGAL is set, a program request first reads the target once. If the request data has a 1 where that read shows a 0, done reports status 2 (illegal) and no write cycle is issued.
- R8: req_ready is high only while no request is in progress. A request is taken only when req_valid and req_ready are both high. done is a single-cycle pulse, and the status code it carries is never 3.
- R9: After reset, CE_n, WE_n and OE_n are high, the data bus is not driven, req_ready is 1 and done is 0.
- R10: A read cycle holds CE_n and OE_n low for STROBE_CLKS clocks with WE_n high. WE_n and OE_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_erase | input | 1 | 1 = chip erase, 0 = byte program |
| req_addr | input | AW | Target address (the polling address for an erase) |
| req_data | input | 8 | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 illegal |
| flash_addr | output | AW | Flash address bus |
| flash_dq_o | output | 8 | Write data toward the flash |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | 8 | Read data from the flash |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest situation to reach is the timeout path. It needs a device that never finishes, so the poll counter has to run to its limit and the reset write has to go out. The bench's flash model has a stuck mode: it returns the inverted DQ7 on every poll until it sees 0xF0 written. The bench also checks that a normal program works afterwards. The illegal path is reached by first programming a byte down to 0x0F and then asking to program 0xF0 at the same location.

// File: rtl/nor_prog_pkg.sv
package nor_prog_pkg;
    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_TIMEOUT = 2'd1,
        ST_ILLEGAL = 2'd2
    } status_e;

    typedef enum logic [2:0] {
        C_IDLE, C_PRECHK, C_CMD, C_POLL, C_ABORT, C_DONE
    } ctrl_e;

    typedef enum logic [1:0] {
        B_IDLE, B_SETUP, B_ACT, B_HOLD
    } bus_e;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ESETUP = 8'h80;
    localparam logic [7:0] CMD_CHIPER = 8'h10;
    localparam logic [7:0] CMD_RESET  = 8'hF0;
endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_prog_pkg::*;
#(
    parameter int AW = 18
) (
    input  logic          is_erase,
    input  logic [2:0]    idx,
    input  logic [AW-1:0] tgt_addr,
    input  logic [7:0]    tgt_data,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          last
);
    localparam logic [AW-1:0] KEY_A1 = AW'(12'h555);
    localparam logic [AW-1:0] KEY_A2 = AW'(12'h2AA);

    always_comb begin
        wr_addr = KEY_A1;
        wr_data = CMD_KEY1;
        unique case (idx)
            3'd0: begin wr_addr = KEY_A1; wr_data = CMD_KEY1; end
            3'd1: begin wr_addr = KEY_A2; wr_data = CMD_KEY2; end
            3'd2: begin wr_addr = KEY_A1; wr_data = is_erase ? CMD_ESETUP : CMD_PROG; end
            3'd3: begin
                wr_addr = is_erase ? KEY_A1 : tgt_addr;
                wr_data = is_erase ? CMD_KEY1 : tgt_data;
            end
            3'd4: begin wr_addr = KEY_A2; wr_data = CMD_KEY2; end
            3'd5: begin wr_addr = KEY_A1; wr_data = CMD_CHIPER; end
            default: begin wr_addr = KEY_A1; wr_data = CMD_KEY1; end
        endcase
        last = is_erase ? (idx == 3'd5) : (idx == 3'd3);
    end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
    import nor_prog_pkg::*;
#(
    parameter int AW          = 18,
    parameter int STROBE_CLKS = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic [7:0]    dq_i,
    output logic          cyc_done,
    output logic [7:0]    rdata,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    dq_o,
    output logic          dq_oe,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n
);
    localparam int CW = (STROBE_CLKS > 1) ? $clog2(STROBE_CLKS) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CLKS - 1);

    typedef struct packed {
        bus_e          phase;
        logic [CW-1:0] cnt;
        logic          wr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [7:0]    rdata;
        logic          done;
    } bus_t;

    bus_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            B_IDLE: if (start) begin
                s_d.phase = B_SETUP;
                s_d.wr    = wr;
                s_d.addr  = addr;
                s_d.data  = wdata;
            end
            B_SETUP: begin
                s_d.phase = B_ACT;
                s_d.cnt   = '0;
            end
            B_ACT: begin
                if (s_q.cnt == CNT_LAST) begin
                    s_d.phase = B_HOLD;
                    if (!s_q.wr) s_d.rdata = dq_i;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            B_HOLD: begin
                s_d.phase = B_IDLE;
                s_d.done  = 1'b1;
            end
            default: s_d.phase = B_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: B_IDLE, cnt: '0, wr: 1'b0, addr: '0,
                     data: '0, rdata: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cyc_done = s_q.done;
    assign rdata    = s_q.rdata;
    assign bus_addr = s_q.addr;
    assign dq_o     = s_q.data;
    assign dq_oe    = s_q.wr && (s_q.phase != B_IDLE);
    assign ce_n     = (s_q.phase != B_ACT);
    assign we_n     = !((s_q.phase == B_ACT) && s_q.wr);
    assign oe_n     = !((s_q.phase == B_ACT) && !s_q.wr);
endmodule

// File: rtl/nor_prog_ctrl.sv
module nor_prog_ctrl
    import nor_prog_pkg::*;
#(
    parameter int AW            = 18,
    parameter int STROBE_CLKS   = 3,
    parameter int MAX_POLLS     = 4096,
    parameter bit CHECK_ILLEGAL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_erase,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          done,
    output logic [1:0]    status,
    output logic [AW-1:0] flash_addr,
    output logic [7:0]    flash_dq_o,
    output logic          flash_dq_oe,
    input  logic [7:0]    flash_dq_i,
    output logic          flash_ce_n,
    output logic          flash_we_n,
    output logic          flash_oe_n
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam logic [PW-1:0] POLL_LAST = PW'(MAX_POLLS - 1);

    typedef struct packed {
        ctrl_e         st;
        logic          erase;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic [2:0]    idx;
        logic [PW-1:0] polls;
        logic          wait_bus;
        status_e       status;
    } ctrl_t;

    ctrl_t c_d, c_q;

    logic          bus_start, bus_wr, bus_done;
    logic [AW-1:0] bus_a;
    logic [7:0]    bus_wd, bus_rd;
    logic [AW-1:0] seq_addr;
    logic [7:0]    seq_data;
    logic          seq_last;
    logic          exp_dq7;

    nor_cmd_seq #(.AW(AW)) u_seq (
        .is_erase (c_q.erase),
        .idx      (c_q.idx),
        .tgt_addr (c_q.addr),
        .tgt_data (c_q.data),
        .wr_addr  (seq_addr),
        .wr_data  (seq_data),
        .last     (seq_last)
    );

    nor_bus_cycle #(.AW(AW), .STROBE_CLKS(STROBE_CLKS)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (bus_start),
        .wr       (bus_wr),
        .addr     (bus_a),
        .wdata    (bus_wd),
        .dq_i     (flash_dq_i),
        .cyc_done (bus_done),
        .rdata    (bus_rd),
        .bus_addr (flash_addr),
        .dq_o     (flash_dq_o),
        .dq_oe    (flash_dq_oe),
        .ce_n     (flash_ce_n),
        .we_n     (flash_we_n),
        .oe_n     (flash_oe_n)
    );

    assign exp_dq7 = c_q.erase ? 1'b1 : c_q.data[7];

    always_comb begin
        c_d       = c_q;
        bus_start = 1'b0;
        bus_wr    = 1'b0;
        bus_a     = c_q.addr;
        bus_wd    = c_q.data;
        unique case (c_q.st)
            C_IDLE: if (req_valid) begin
                c_d.erase    = req_erase;
                c_d.addr     = req_addr;
                c_d.data     = req_data;
                c_d.idx      = '0;
                c_d.polls    = '0;
                c_d.wait_bus = 1'b0;
                c_d.st       = (CHECK_ILLEGAL && !req_erase) ? C_PRECHK : C_CMD;
            end
            C_PRECHK: begin
                bus_start = !c_q.wait_bus;
                if (!c_q.wait_bus) c_d.wait_bus = 1'b1;
                else if (bus_done) begin
                    c_d.wait_bus = 1'b0;
                    if ((c_q.data & ~bus_rd) != 8'h00) begin
                        c_d.status = ST_ILLEGAL;
                        c_d.st     = C_DONE;
                    end else begin
                        c_d.st = C_CMD;
                    end
                end
            end
            C_CMD: begin
                bus_wr    = 1'b1;
                bus_a     = seq_addr;
                bus_wd    = seq_data;
                bus_start = !c_q.wait_bus;
                if (!c_q.wait_bus) c_d.wait_bus = 1'b1;
                else if (bus_done) begin
                    c_d.wait_bus = 1'b0;
                    if (seq_last) c_d.st = C_POLL;
                    else          c_d.idx = c_q.idx + 1'b1;
                end
            end
            C_POLL: begin
                bus_start = !c_q.wait_bus;
                if (!c_q.wait_bus) c_d.wait_bus = 1'b1;
                else if (bus_done) begin
                    c_d.wait_bus = 1'b0;
                    if (bus_rd[7] == exp_dq7) begin
                        c_d.status = ST_OK;
                        c_d.st     = C_DONE;
                    end else if (c_q.polls == POLL_LAST) begin
                        c_d.st = C_ABORT;
                    end else begin
                        c_d.polls = c_q.polls + 1'b1;
                    end
                end
            end
            C_ABORT: begin
                bus_wr    = 1'b1;
                bus_a     = '0;
                bus_wd    = CMD_RESET;
                bus_start = !c_q.wait_bus;
                if (!c_q.wait_bus) c_d.wait_bus = 1'b1;
                else if (bus_done) begin
                    c_d.wait_bus = 1'b0;
                    c_d.status   = ST_TIMEOUT;
                    c_d.st       = C_DONE;
                end
            end
            C_DONE:  c_d.st = C_IDLE;
            default: c_d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: C_IDLE, erase: 1'b0, addr: '0, data: '0, idx: '0,
                     polls: '0, wait_bus: 1'b0, status: ST_OK};
        end else begin
            c_q <= c_d;
        end
    end

    assign req_ready = (c_q.st == C_IDLE);
    assign done      = (c_q.st == C_DONE);
    assign status    = c_q.status;
endmodule

// File: rtl/nor_prog_ctrl_chk.sv
module nor_prog_ctrl_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          done,
    input logic [1:0]    status,
    input logic [AW-1:0] flash_addr,
    input logic [7:0]    flash_dq_o,
    input logic          flash_dq_oe,
    input logic          flash_ce_n,
    input logic          flash_we_n,
    input logic          flash_oe_n
);
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!flash_we_n && !flash_oe_n)); // R10
    AST_ADDR_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_ce_n) |-> $stable(flash_addr)); // R3
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_ce_n && $past(!flash_ce_n)) |-> $stable(flash_addr)); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_we_n) |-> (flash_dq_oe && $stable(flash_dq_o))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (flash_ce_n && !flash_dq_oe)); // R8
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (status != 2'd3)); // R8
endmodule

bind nor_prog_ctrl nor_prog_ctrl_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .done        (done),
    .status      (status),
    .flash_addr  (flash_addr),
    .flash_dq_o  (flash_dq_o),
    .flash_dq_oe (flash_dq_oe),
    .flash_ce_n  (flash_ce_n),
    .flash_we_n  (flash_we_n),
    .flash_oe_n  (flash_oe_n)
);

// File: tb/nor_prog_ctrl_test.sv
module nor_prog_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int SCLK = 3;
    localparam int MAXP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic req_ready, done, dq_oe, ce_n, we_n, oe_n;
    logic [1:0] status;
    logic [AW-1:0] faddr;
    logic [7:0] dq_o, dq_i;

    int tests = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_prog_ctrl #(.AW(AW), .STROBE_CLKS(SCLK), .MAX_POLLS(MAXP), .CHECK_ILLEGAL(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_erase(req_erase), .req_addr(req_addr), .req_data(req_data),
        .done(done), .status(status), .flash_addr(faddr), .flash_dq_o(dq_o),
        .flash_dq_oe(dq_oe), .flash_dq_i(dq_i), .flash_ce_n(ce_n),
        .flash_we_n(we_n), .flash_oe_n(oe_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural flash model
    logic [7:0] mem [0:(1<<AW)-1];
    logic [AW+7:0] wq [$];
    int busy = 0, busy_set = 0, nreads = 0, wlow = 0, rlow = 0;
    bit stuck = 0, exp7 = 0, op_active = 0;
    logic [AW-1:0] tgt = '0;
    int bad_rd = 0;
    logic prev_we = 1, prev_ce = 1, prev_oe = 1;

    assign dq_i = (busy > 0 || stuck) ? {~exp7, 7'h00} : mem[faddr];

    always @(negedge clk) begin
        if (rst_n) begin
            // cycle-wise reference compare of handshake state
            chk(req_ready == !op_active, "R8 ready", req_ready, !op_active);
            if (!we_n && !oe_n) chk(0, "R10 we/oe overlap", 1, 0);
            if (!we_n && !dq_oe) chk(0, "R3 data not driven in strobe", 0, 1);
            if (!we_n) wlow++;
            else if (!prev_we) begin
                chk(wlow == SCLK, "R3 write strobe width", wlow, SCLK);
                wlow = 0;
            end
            if (!oe_n) begin
                rlow++;
                if (!we_n || ce_n) chk(0, "R10 read strobes", {we_n, ce_n}, 2'b10);
            end else if (!prev_oe) begin
                chk(rlow == SCLK, "R10 read strobe width", rlow, SCLK);
                rlow = 0;
                nreads++;
                if (faddr != tgt) bad_rd++;
                if (busy > 0) busy--;
            end
            if (!prev_we && we_n && !prev_ce) begin
                wq.push_back({faddr, dq_o});
                if (dq_o == 8'hF0) begin stuck = 0; busy = 0; end
                else if (wq.size() == 4 && wq[2][7:0] == 8'hA0) begin
                    mem[faddr] = mem[faddr] & dq_o;
                    exp7 = dq_o[7]; busy = busy_set;
                end else if (wq.size() == 6 && wq[5][7:0] == 8'h10) begin
                    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
                    exp7 = 1'b1; busy = busy_set;
                end
            end
            if (done) op_active = 0;
        end
        prev_we = we_n; prev_ce = ce_n; prev_oe = oe_n;
    end

    task automatic run_op(input bit erase, input logic [AW-1:0] a, input logic [7:0] d,
                          input int k, input bit stk, input int exp_st,
                          input int exp_rd, input string req);
        logic [AW+7:0] ew [$];
        int cyc = 0;
        ew = {};
        if (exp_st != 2) begin
            ew.push_back({12'h555, 8'hAA});
            ew.push_back({12'h2AA, 8'h55});
            if (erase) begin
                ew.push_back({12'h555, 8'h80});
                ew.push_back({12'h555, 8'hAA});
                ew.push_back({12'h2AA, 8'h55});
                ew.push_back({12'h555, 8'h10});
            end else begin
                ew.push_back({12'h555, 8'hA0});
                ew.push_back({a, d});
            end
            if (exp_st == 1) ew.push_back({12'h000, 8'hF0});
        end
        @(negedge clk); #1;
        wq = {}; nreads = 0; bad_rd = 0; tgt = a;
        busy_set = k; stuck = stk;
        if (stk) exp7 = ~d[7];
        req_valid = 1; req_erase = erase; req_addr = a; req_data = d;
        @(posedge clk); #1;
        op_active = 1; req_valid = 0;
        while (!done && cyc < 2000) begin @(negedge clk); #1; cyc++; end
        chk(done == 1'b1, {req, " done seen"}, done, 1);
        chk(int'(status) == exp_st, {req, " status"}, status, exp_st);
        chk(nreads == exp_rd, {req, " read count"}, nreads, exp_rd);
        chk(bad_rd == 0, {req, " poll address"}, bad_rd, 0);
        chk(wq.size() == ew.size(), {req, " write count"}, wq.size(), ew.size());
        for (int i = 0; i < ew.size() && i < wq.size(); i++)
            chk(wq[i] == ew[i], {req, " write cycle"}, wq[i], ew[i]);
        @(negedge clk); #1;
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk({ce_n, we_n, oe_n} == 3'b111, "R9 strobes idle", {ce_n, we_n, oe_n}, 7);
        chk(dq_oe == 0, "R9 bus released", dq_oe, 0);
        chk(req_ready == 1 && done == 0, "R9 ready/done", {req_ready, done}, 2);
        // R1 R4: program with 3 busy polls, prechk adds one read
        run_op(0, 12'h123, 8'h5A, 3, 0, 0, 5, "R1 R4 program");
        // R4: bit7 expected 0
        run_op(0, 12'h010, 8'h00, 0, 0, 0, 2, "R4 program dq7=0");
        // R2 R4: erase, expected dq7 = 1
        run_op(1, 12'h000, 8'h00, 5, 0, 0, 6, "R2 R4 erase");
        // R7 setup then illegal request
        run_op(0, 12'h020, 8'h0F, 1, 0, 0, 3, "R7 legal program");
        run_op(0, 12'h020, 8'hF0, 0, 0, 2, 1, "R7 illegal program");
        // R5 R6: stuck device times out
        run_op(0, 12'h030, 8'h80, 0, 1, 1, 1 + MAXP, "R5 R6 timeout");
        // recovery after timeout
        run_op(0, 12'h031, 8'hC3, 2, 0, 0, 4, "R6 recovery");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++; tests++;
        $display("FAIL R8 watchdog actual=hang expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule